// File: doc/BRIEF.md
# Signed Iterative Divider With Remainder

This block divides one signed two's-complement word by another and returns both a quotient and a remainder. It is meant to sit behind a control sequencer that needs an occasional divide and can wait a fixed number of cycles for it. A single-cycle `start` strobe, given while the block is idle, captures both operands. The block then turns each operand into its unsigned magnitude and runs a restoring division that produces one quotient bit per clock. A final cycle applies the sign rules and registers the results.

Division truncates toward zero. The remainder takes the sign of the dividend, and the quotient is negated when the two operand signs differ. A zero divisor is not an exception: it takes the same number of cycles, returns an all-ones quotient, returns the dividend unchanged as the remainder, and raises a flag. The most negative dividend is handled by reading its negation as an unsigned magnitude one larger than the largest positive value.

Top module: `sdiv_iter`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero until the first division completes.
- R2: A `start` seen at a rising edge while `busy` is low is accepted. `busy` is high for the W+1 cycles that follow. `done` is a single-cycle pulse in the cycle after those, so it is observed W+2 rising edges after the accepting edge, counting that edge, and `busy` is low while `done` is high.
- R3: For two non-negative operands with a non-zero divisor, `quotient` is the integer quotient and `remainder` is what is left over, so that dividend = quotient*divisor + remainder and 0 <= remainder < divisor.
- R4: With a non-zero divisor, `quotient` is truncated toward zero: its magnitude is that of |dividend|/|divisor|, and it is negated when exactly one operand is negative. `remainder` has the magnitude |dividend| mod |divisor| and is negated when the dividend is negative.
- R5: A divisor of zero completes with the same timing as any other division. It returns `quotient` with all bits set and `remainder` equal to the dividend, and `div_by_zero` is 1.
- R6: A dividend of -2^(W-1) (0x8000 at W=16) is divided as the magnitude 2^(W-1). Its quotient by -1 is 2^(W-1), which in W bits reads back as 0x8000.
- R7: A `start` given while `busy` is high has no effect. That division's result is unchanged and no extra `done` pulse follows.
- R8: `quotient`, `remainder` and `div_by_zero` stay unchanged after `done` until the next accepted division completes, whatever the operand inputs do in between.
- R9: `div_by_zero` is 0 after any division whose divisor was non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a division with the present operands; honoured only while idle |
| dividend | input | W | Signed dividend |
| divisor | input | W | Signed divisor |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse marking that new results are present |
| quotient | output | W | Signed quotient, truncated toward zero |
| remainder | output | W | Signed remainder, sign of the dividend |
| div_by_zero | output | 1 | The last completed division had a zero divisor |

## Verification
The bench builds the block at its default width of 16 bits. At that width the extreme operands can be driven directly: 0x8000 as dividend and as divisor, -1, 0 and 0x7FFF. These make the one-bit-wider magnitude, the wrapped quotient of -32768/-1 and the zero-divisor path visible at the ports. A run of pseudo-random operand pairs covers all four sign combinations. The latency is counted from the accepting edge to `done` at exactly 18 edges.

// File: rtl/sdiv_pkg.sv
// Package: shared types for the signed iterative divider.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package sdiv_pkg;

    // Sequencing phase of the divider core.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for start
        ST_RUN  = 2'd1,   // one quotient bit per cycle
        ST_FIX  = 2'd2    // sign correction and result capture
    } phase_t;

endpackage

// File: rtl/sdiv_mag.sv
// Module: sdiv_mag
// Converts a signed W-bit operand into its unsigned magnitude and a sign flag.
// Assumes: the most negative value maps to magnitude 2^(W-1), which is
// representable as an unsigned W-bit number.
module sdiv_mag #(
    parameter int W = 16
) (
    input  logic [W-1:0] value,
    output logic [W-1:0] mag,
    output logic         neg
);

    // Purpose: take the sign bit and the absolute value as unsigned.
    always_comb begin
        neg = value[W-1];
        mag = neg ? (~value + {{(W-1){1'b0}}, 1'b1}) : value;
    end

endmodule

// File: rtl/sdiv_core.sv
// Module: sdiv_core
// Restoring unsigned division, one quotient bit per clock, plus the phase
// sequencer (idle, W run cycles, one fix cycle).
// Assumes: W >= 2; operand magnitudes are presented in the accepting cycle.
module sdiv_core
    import sdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dd_mag,
    input  logic [W-1:0] ds_mag,
    output logic         accept,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] q_mag,
    output logic [W-1:0] r_mag
);

    localparam int             CW   = $clog2(W);
    localparam logic [CW-1:0]  LAST = CW'(W - 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;
    logic [W:0]    shifted;
    logic [W+1:0]  diff;
    logic          no_borrow;

    // Purpose: derive the handshake views of the phase.
    always_comb begin
        busy   = (phase != ST_IDLE);
        fin    = (phase == ST_FIX);
        accept = start && (phase == ST_IDLE);
    end

    // Purpose: one trial subtraction of the divisor from the shifted remainder.
    always_comb begin
        shifted   = {rem_q, quo_q[W-1]};
        diff      = {1'b0, shifted} - {2'b00, dvs_q};
        no_borrow = ~diff[W+1];
    end

    // Purpose: phase sequencing and the partial remainder / quotient shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_IDLE;
            cnt   <= '0;
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else begin
            case (phase)
                ST_IDLE: begin
                    if (start) begin
                        rem_q <= '0;
                        quo_q <= dd_mag;
                        dvs_q <= ds_mag;
                        cnt   <= '0;
                        phase <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    quo_q <= {quo_q[W-2:0], no_borrow};
                    rem_q <= no_borrow ? diff[W-1:0] : shifted[W-1:0];
                    cnt   <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        phase <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    phase <= ST_IDLE;
                end
                default: begin
                    phase <= ST_IDLE;
                end
            endcase
        end
    end

    assign q_mag = quo_q;
    assign r_mag = rem_q;

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_RUN && dvs_q != '0) |-> (rem_q < dvs_q)); // R3
    AST_FIX_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_FIX) |-> ($past(phase) == ST_RUN)); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(dvs_q)); // R7

endmodule

// File: rtl/sdiv_fix.sv
// Module: sdiv_fix
// Applies the truncating sign rules to the unsigned results and the
// zero-divisor override.
// Assumes: magnitudes come from the restoring core; flags describe the
// operands captured at acceptance.
module sdiv_fix #(
    parameter int W = 16
) (
    input  logic [W-1:0] q_mag,
    input  logic [W-1:0] r_mag,
    input  logic         neg_dd,
    input  logic         neg_ds,
    input  logic         dbz,
    output logic [W-1:0] q_out,
    output logic [W-1:0] r_out
);

    // Purpose: negate quotient on sign mismatch, remainder on negative dividend.
    always_comb begin
        if (dbz) begin
            q_out = '1;
        end else if (neg_dd ^ neg_ds) begin
            q_out = ~q_mag + {{(W-1){1'b0}}, 1'b1};
        end else begin
            q_out = q_mag;
        end
        r_out = neg_dd ? (~r_mag + {{(W-1){1'b0}}, 1'b1}) : r_mag;
    end

endmodule

// File: rtl/sdiv_iter.sv
// Module: sdiv_iter (top)
// Multicycle signed divider: magnitude conversion, restoring core, sign fix
// and registered outputs with a start/busy/done handshake.
// Assumes: start is a synchronous strobe; operands are valid with it.
module sdiv_iter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);

    localparam int NOPS = 2;   // operand 0 = dividend, 1 = divisor

    logic [NOPS-1:0][W-1:0] opnd;
    logic [NOPS-1:0][W-1:0] mag;
    logic [NOPS-1:0]        neg;
    logic                   accept;
    logic                   fin;
    logic [W-1:0]           q_mag;
    logic [W-1:0]           r_mag;
    logic [W-1:0]           q_fix;
    logic [W-1:0]           r_fix;
    logic                   neg_dd_q;
    logic                   neg_ds_q;
    logic                   dbz_q;

    assign opnd[0] = dividend;
    assign opnd[1] = divisor;

    for (genvar g = 0; g < NOPS; g++) begin : g_mag
        sdiv_mag #(.W(W)) i_mag (
            .value (opnd[g]),
            .mag   (mag[g]),
            .neg   (neg[g])
        );
    end

    sdiv_core #(.W(W)) i_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .dd_mag (mag[0]),
        .ds_mag (mag[1]),
        .accept (accept),
        .busy   (busy),
        .fin    (fin),
        .q_mag  (q_mag),
        .r_mag  (r_mag)
    );

    sdiv_fix #(.W(W)) i_fix (
        .q_mag  (q_mag),
        .r_mag  (r_mag),
        .neg_dd (neg_dd_q),
        .neg_ds (neg_ds_q),
        .dbz    (dbz_q),
        .q_out  (q_fix),
        .r_out  (r_fix)
    );

    // Purpose: remember operand signs and zero divisor at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_dd_q <= 1'b0;
            neg_ds_q <= 1'b0;
            dbz_q    <= 1'b0;
        end else if (accept) begin
            neg_dd_q <= neg[0];
            neg_ds_q <= neg[1];
            dbz_q    <= (divisor == '0);
        end
    end

    // Purpose: capture results in the fix cycle and hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quotient    <= '0;
            remainder   <= '0;
            div_by_zero <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                quotient    <= q_fix;
                remainder   <= r_fix;
                div_by_zero <= dbz_q;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero))); // R8
    AST_DBZ_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_by_zero) |-> (quotient == '1)); // R5

endmodule

// File: tb/test_sdiv_iter.sv
module test_sdiv_iter;

    localparam int W = 16;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] r;
        logic         dbz;
        int           t0;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         div_by_zero;

    int   n_chk = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   n_issued = 0;
    int   n_done = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    sdiv_iter #(.W(W)) i_sdiv_iter (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dividend    (dividend),
        .divisor     (divisor),
        .busy        (busy),
        .done        (done),
        .quotient    (quotient),
        .remainder   (remainder),
        .div_by_zero (div_by_zero)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: issue one accepted division and push its expected outcome.
    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b);
        exp_t   e;
        longint ia, ib;
        ia = longint'($signed(a));
        ib = longint'($signed(b));
        if (ib == 0) begin
            e.q = '1; e.r = a; e.dbz = 1'b1; e.tag = "R5";
        end else begin
            e.q = W'(ia / ib); e.r = W'(ia % ib); e.dbz = 1'b0;
            if (a == {1'b1, {(W-1){1'b0}}}) e.tag = "R6";
            else if (ia < 0 || ib < 0)     e.tag = "R4";
            else                           e.tag = "R3";
        end
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        e.t0 = cyc;
        sb.push_back(e);
        n_issued++;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2", "busy after accept", busy, 1);
    endtask

    task automatic run_one(input logic [W-1:0] a, input logic [W-1:0] b);
        issue(a, b);
        wait (sb.size() == 0);
        @(negedge clk);
        check(done === 1'b0, "R2", "done single pulse", done, 0);
    endtask

    // Monitor: compare each completion against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && done) begin
            n_done++;
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(quotient === e.q, e.tag, "quotient", quotient, e.q);
                check(remainder === e.r, e.tag, "remainder", remainder, e.r);
                check(div_by_zero === e.dbz, e.dbz ? "R5" : "R9", "div_by_zero",
                      div_by_zero, e.dbz);
                check(cyc - e.t0 == W + 2, "R2", "latency edges", cyc - e.t0, W + 2);
                check(busy === 1'b0, "R2", "busy low with done", busy, 0);
            end
        end
    end

    initial begin
        logic [W-1:0] hq, hr;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(quotient === '0 && remainder === '0, "R1", "results after reset",
              {quotient, remainder}, 0);
        check(div_by_zero === 1'b0 && busy === 1'b0, "R1", "flags after reset",
              {div_by_zero, busy}, 0);

        // R3: non-negative operands
        run_one(16'd100, 16'd7);
        run_one(16'd7, 16'd100);
        run_one(16'd0, 16'd5);
        run_one(16'h7FFF, 16'd1);
        run_one(16'h7FFF, 16'h7FFF);
        // R4: sign combinations
        run_one(-16'sd100, 16'd7);
        run_one(16'd100, -16'sd7);
        run_one(-16'sd100, -16'sd7);
        run_one(-16'sd1, 16'h8000);
        run_one(16'h7FFF, 16'h8000);
        // R6: most negative dividend
        run_one(16'h8000, 16'hFFFF);
        run_one(16'h8000, 16'd1);
        run_one(16'h8000, 16'd3);
        run_one(16'h8000, 16'h8000);
        // R5: zero divisor
        run_one(16'd12345, 16'd0);
        run_one(-16'sd12345, 16'd0);
        run_one(16'h8000, 16'd0);
        run_one(16'd0, 16'd0);
        // R9: non-zero divisor after a zero one clears the flag
        run_one(16'd9, 16'd3);

        // R7: start while busy is ignored
        issue(16'd1000, 16'd9);
        repeat (3) @(negedge clk);
        dividend = 16'd5; divisor = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (sb.size() == 0);
        repeat (W + 6) @(negedge clk);
        check(n_done == n_issued, "R7", "done count", n_done, n_issued);

        // R8: results hold while inputs move without start
        hq = quotient; hr = remainder;
        for (int k = 0; k < 8; k++) begin
            dividend = W'(k * 977); divisor = W'(k);
            @(negedge clk);
        end
        check(quotient === hq, "R8", "quotient held", quotient, hq);
        check(remainder === hr, "R8", "remainder held", remainder, hr);

        // pseudo-random pairs across R3/R4
        for (int k = 0; k < 150; k++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = W'($urandom);
            if (k % 3 == 0) b = W'($signed(b) >>> 10);
            run_one(a, b);
        end

        check(n_done == n_issued, "R7", "final done count", n_done, n_issued);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule